// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block holds the five status flags of an I2C controller that can act as bus master or as addressed slave. It looks at the synchronised SCL and SDA levels and at event strobes from the byte engine: start, repeated start, stop, the position of the current bit within its byte, each completed received byte, the level the node drives onto SDA, and whether the node is currently generating a start or stop condition. It also sees single-cycle write strobes from the control register, together with the current interrupt-flag and master-select levels.

From these inputs it keeps five flags. The first reports lost arbitration. The second holds the last acknowledge bit seen. The third tells whether the node is the transmitter. The fourth tells whether the node was addressed as slave, by a 7-bit or a 10-bit address. The fifth tells whether a general call was received. Every flag is a register and changes on the clock edge that samples its cause. A control-register write that clears a flag wins over a hardware event that would set it in the same cycle. A bus event that clears a flag wins over a set in the same cycle.

Top module: `i2c_status_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all five flags read 0.
- R2: arb_lost becomes 1 on the edge that samples an SCL rise while mss=1, xmit=1, sda_out=1, sda_in=0 and bit_idx is not 8.
- R3: arb_lost becomes 1 when ev_rstart arrives while mss=1, cond_gen=0, bit_idx=0, and at least one byte has completed since the last start.
- R4: arb_lost becomes 1 when SCL falls from 1 to 0 while cond_gen=1.
- R5: arb_lost clears after a wr_int_clr strobe, or after wr_mss with wr_mss_val=1. Such a write wins over a same-cycle set event.
- R6: On an SCL rise with bit_idx=8, last_bit captures sda_in (0 = acknowledge, 1 = no acknowledge). Any start, repeated start or stop clears it, and that clear wins.
- R7: xmit becomes 1 on ev_start or ev_rstart while mss=1. It also becomes 1 when, with mss=0, the first byte after a start has bits [7:1] equal to own_addr[6:0], ten_bit_en=0 and bit 0 = 1 (read).
- R8: xmit clears on a stop while the bus is busy, and on any arbitration loss. It also clears when, with mss=1 and int_flag=1, either wr_scc_set or wr_mss with wr_mss_val=0 is strobed. A write with int_flag=0 leaves it unchanged. Clears win over sets.
- R9: xmit clears when a slave transmitter (mss=0, xmit=1) samples sda_in=1 at the bit-8 SCL rise. It also clears on a slave write-address match, and at the bit-8 SCL rise after the first byte when the master sent bit 0 = 1.
- R10: In 7-bit mode (ten_bit_en=0), addr_slave becomes 1 only when mss=0 and the first byte after a start has bits [7:1] equal to own_addr[6:0].
- R11: In 10-bit mode (ten_bit_en=1), addr_slave becomes 1 only when mss=0, the first byte is 11110, own_addr[9:8], R/W, and the second byte equals own_addr[7:0].
- R12: gen_call becomes 1 when mss=0 and the first byte after a start is 0x00.
- R13: addr_slave and gen_call clear on a start, a repeated start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| sda_out | input | 1 | Level this node drives on SDA (1 = released) |
| cond_gen | input | 1 | Node is generating a start or stop condition |
| bit_idx | input | 4 | Bit position in current byte, 8 = acknowledge |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start strobe |
| ev_stop | input | 1 | Stop condition strobe |
| byte_done | input | 1 | A byte has been received, in rx_byte |
| rx_byte | input | 8 | Received byte |
| own_addr | input | 10 | Own slave address |
| ten_bit_en | input | 1 | 10-bit addressing selected |
| mss | input | 1 | Master-select level |
| int_flag | input | 1 | Interrupt-flag level |
| wr_int_clr | input | 1 | Strobe: 0 written to interrupt flag |
| wr_mss | input | 1 | Strobe: master-select written |
| wr_mss_val | input | 1 | Value written with wr_mss |
| wr_scc_set | input | 1 | Strobe: 1 written to start-repeat bit |
| arb_lost | output | 1 | Arbitration lost |
| last_bit | output | 1 | Last acknowledge bit seen |
| xmit | output | 1 | Node is transmitting |
| addr_slave | output | 1 | Addressed as slave |
| gen_call | output | 1 | General call received |

## Verification
The bench drives collisions between a clearing write and a same-cycle set: a mismatch together with wr_int_clr must leave arb_lost at 0, and a design that lets the set win would raise it. A master-select write made without a pending interrupt must leave xmit untouched; a design that ignores the interrupt qualifier drops it. In 10-bit mode the bench pairs a correct prefix with a wrong low byte, and a wrong prefix with a correct low byte; matching on one byte alone would raise addr_slave. A repeated start from another master after a full byte must raise arb_lost and drop xmit, while the node's own repeated start must not.

// File: rtl/i2c_flag_pkg.sv
// Shared constants and types for the I2C status flag tracker.
// Assumes byte positions counted 0..8 with 8 as the acknowledge slot.
package i2c_flag_pkg;
    localparam int BIT_W   = 4;
    localparam int ACK_IDX = 8;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam logic [4:0]        TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_BYTE    = 8'h00;

    // Where the address decoder stands within the current transfer.
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_DATA   = 2'd2
    } addr_phase_t;
endpackage

// File: rtl/i2c_scl_edge.sv
// Registers the SCL level and reports one-cycle rise and fall pulses.
// Assumes scl_in is already synchronised; idle level is high.
module i2c_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;

    // Hold the previous SCL sample; reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_in;
    end

    // Compare current and previous samples for edges.
    always_comb begin
        scl_rise = scl_in & ~scl_q;
        scl_fall = ~scl_in & scl_q;
    end
endmodule

// File: rtl/i2c_addr_decode.sv
// Tracks the address bytes after each start and reports slave matches.
// Assumes byte_done pulses once per received byte, the first byte after a
// start being the address. In 10-bit mode a prefix byte precedes the low byte.
module i2c_addr_decode
    import i2c_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ev,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_en,
    input  logic              ack_evt,
    output logic              hit_own,
    output logic              hit_read,
    output logic              hit_gc,
    output logic              first_done,
    output logic              addr_ack_due,
    output logic              first_rw
);
    addr_phase_t phase_q;
    logic        hi_ok_q;
    logic        pend_q;
    logic        rw_q;
    logic        is_first, is_second, m7, pfx_ok, m10;

    // Classify the incoming byte and compare it against the own address.
    always_comb begin
        is_first  = byte_done && (phase_q == PH_FIRST);
        is_second = byte_done && (phase_q == PH_SECOND);
        m7        = is_first && !ten_bit_en && (rx_byte[7:1] == own_addr[6:0]);
        pfx_ok    = is_first && ten_bit_en && (rx_byte[7:3] == TEN_PREFIX)
                    && (rx_byte[2:1] == own_addr[9:8]);
        m10       = is_second && hi_ok_q && (rx_byte == own_addr[7:0]);
        hit_own   = m7 | m10;
        hit_read  = m7 & rx_byte[0];
        hit_gc    = is_first && (rx_byte == GC_BYTE);
    end

    // Advance the address phase; any bus condition restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev)  phase_q <= PH_FIRST;
        else if (is_first)     phase_q <= pfx_ok ? PH_SECOND : PH_DATA;
        else if (is_second)    phase_q <= PH_DATA;
    end

    // Remember whether the 10-bit prefix matched.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev) hi_ok_q <= 1'b0;
        else if (is_first)    hi_ok_q <= pfx_ok;
    end

    // Latch the R/W bit of the first byte and flag its pending acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev) begin
            pend_q <= 1'b0;
            rw_q   <= 1'b0;
        end else if (is_first) begin
            pend_q <= 1'b1;
            rw_q   <= rx_byte[0];
        end else if (ack_evt) begin
            pend_q <= 1'b0;
        end
    end

    assign first_done   = (phase_q != PH_FIRST);
    assign addr_ack_due = pend_q;
    assign first_rw     = rw_q;

    // R11
    ten_needs_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_SECOND) |-> hi_ok_q);
endmodule

// File: rtl/i2c_arb_monitor.sv
// Keeps the arbitration-lost flag and reports each loss event.
// Assumes mss/trx describe the node's role in the current cycle; clearing
// register writes beat any same-cycle loss event.
module i2c_arb_monitor
    import i2c_flag_pkg::*;
#(
    parameter int BW  = BIT_W,
    parameter int ACK = ACK_IDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_in,
    input  logic          sda_out,
    input  logic          cond_gen,
    input  logic [BW-1:0] bit_idx,
    input  logic          ev_rstart,
    input  logic          mss,
    input  logic          trx,
    input  logic          first_done,
    input  logic          wr_int_clr,
    input  logic          wr_mss,
    input  logic          wr_mss_val,
    output logic          arb_lost,
    output logic          loss_evt
);
    localparam logic [BW-1:0] ACK_POS = BW'(ACK);

    logic mism, foreign_rs, cond_fail, wclr;

    // Detect the three loss causes and the clearing writes.
    always_comb begin
        mism       = scl_rise && mss && trx && sda_out && !sda_in && (bit_idx != ACK_POS);
        foreign_rs = ev_rstart && mss && !cond_gen && (bit_idx == '0) && first_done;
        cond_fail  = cond_gen && scl_fall;
        loss_evt   = mism | foreign_rs | cond_fail;
        wclr       = wr_int_clr | (wr_mss & wr_mss_val);
    end

    // Flag register: write clear first, then loss set.
    always_ff @(posedge clk) begin
        if (!rst_n)        arb_lost <= 1'b0;
        else if (wclr)     arb_lost <= 1'b0;
        else if (loss_evt) arb_lost <= 1'b1;
    end

    // R2
    mismatch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && mss && trx && sda_out && !sda_in && bit_idx != ACK_POS && !wr_int_clr && !wr_mss)
        |=> arb_lost);
    // R4
    cond_fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_gen && scl_fall && !wr_int_clr && !wr_mss) |=> arb_lost);
    // R5
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_int_clr || (wr_mss && wr_mss_val)) |=> !arb_lost);
endmodule

// File: rtl/i2c_status_flags.sv
// Top of the status flag tracker: last-ack, transmit, addressed and
// general-call flags, plus bus-busy tracking, around the arbitration monitor
// and address decoder. Assumes all event and write inputs are one-cycle strobes.
module i2c_status_flags
    import i2c_flag_pkg::*;
#(
    parameter int BW  = BIT_W,
    parameter int ACK = ACK_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              sda_out,
    input  logic              cond_gen,
    input  logic [BW-1:0]     bit_idx,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_en,
    input  logic              mss,
    input  logic              int_flag,
    input  logic              wr_int_clr,
    input  logic              wr_mss,
    input  logic              wr_mss_val,
    input  logic              wr_scc_set,
    output logic              arb_lost,
    output logic              last_bit,
    output logic              xmit,
    output logic              addr_slave,
    output logic              gen_call
);
    localparam logic [BW-1:0] ACK_POS = BW'(ACK);

    logic scl_rise, scl_fall;
    logic bus_ev, busy_q, idle_evt, ack_evt;
    logic hit_own, hit_read, hit_gc, first_done, addr_ack_due, first_rw;
    logic loss_evt, slave_hit;
    logic trx_wclr, trx_hclr, trx_set;

    i2c_scl_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_addr_decode u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ev       (bus_ev),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .own_addr     (own_addr),
        .ten_bit_en   (ten_bit_en),
        .ack_evt      (ack_evt),
        .hit_own      (hit_own),
        .hit_read     (hit_read),
        .hit_gc       (hit_gc),
        .first_done   (first_done),
        .addr_ack_due (addr_ack_due),
        .first_rw     (first_rw)
    );

    i2c_arb_monitor #(.BW(BW), .ACK(ACK)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_in     (sda_in),
        .sda_out    (sda_out),
        .cond_gen   (cond_gen),
        .bit_idx    (bit_idx),
        .ev_rstart  (ev_rstart),
        .mss        (mss),
        .trx        (xmit),
        .first_done (first_done),
        .wr_int_clr (wr_int_clr),
        .wr_mss     (wr_mss),
        .wr_mss_val (wr_mss_val),
        .arb_lost   (arb_lost),
        .loss_evt   (loss_evt)
    );

    // Combine bus events and the role-dependent set/clear causes.
    always_comb begin
        bus_ev    = ev_start | ev_rstart | ev_stop;
        idle_evt  = busy_q & ev_stop;
        ack_evt   = scl_rise && (bit_idx == ACK_POS);
        slave_hit = hit_own & ~mss;
        trx_wclr  = mss & int_flag & (wr_scc_set | (wr_mss & ~wr_mss_val));
        trx_hclr  = idle_evt | loss_evt
                  | (ack_evt & ~mss & xmit & sda_in)
                  | (ack_evt & mss & addr_ack_due & first_rw)
                  | (slave_hit & ~hit_read);
        trx_set   = ((ev_start | ev_rstart) & mss) | (slave_hit & hit_read);
    end

    // Bus-busy: raised by a start, dropped by a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy_q <= 1'b0;
        else if (ev_start || ev_rstart) busy_q <= 1'b1;
        else if (ev_stop)               busy_q <= 1'b0;
    end

    // Last acknowledge bit, cleared by any bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev) last_bit <= 1'b0;
        else if (ack_evt)     last_bit <= sda_in;
    end

    // Transmit flag: write clears, then hardware clears, then sets.
    always_ff @(posedge clk) begin
        if (!rst_n)        xmit <= 1'b0;
        else if (trx_wclr) xmit <= 1'b0;
        else if (trx_hclr) xmit <= 1'b0;
        else if (trx_set)  xmit <= 1'b1;
    end

    // Addressed-as-slave flag.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev) addr_slave <= 1'b0;
        else if (slave_hit)   addr_slave <= 1'b1;
    end

    // General-call flag, only while not master.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_ev)  gen_call <= 1'b0;
        else if (hit_gc && !mss) gen_call <= 1'b1;
    end

    // R6
    lrb_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start || ev_rstart || ev_stop) |=> !last_bit);
    // R13
    slave_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start || ev_rstart || ev_stop) |=> (!addr_slave && !gen_call));
    // R8
    loss_drops_trx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> !xmit);
    // R8
    scc_drops_trx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mss && int_flag && wr_scc_set) |=> !xmit);
    // R12
    no_gc_as_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call) |-> !$past(mss));
endmodule

// File: tb/tb_i2c_status_flags.sv
`timescale 1ns/100ps
module tb_i2c_status_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1, sda_out = 1'b1, cond_gen = 1'b0;
    logic [3:0] bit_idx = '0;
    logic       ev_start = 0, ev_rstart = 0, ev_stop = 0, byte_done = 0;
    logic [7:0] rx_byte = '0;
    logic [9:0] own_addr = 10'h052;
    logic       ten_bit_en = 1'b0, mss = 1'b0, int_flag = 1'b0;
    logic       wr_int_clr = 0, wr_mss = 0, wr_mss_val = 0, wr_scc_set = 0;
    logic       arb_lost, last_bit, xmit, addr_slave, gen_call;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_status_flags dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_out(sda_out), .cond_gen(cond_gen), .bit_idx(bit_idx),
        .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .byte_done(byte_done), .rx_byte(rx_byte), .own_addr(own_addr),
        .ten_bit_en(ten_bit_en), .mss(mss), .int_flag(int_flag),
        .wr_int_clr(wr_int_clr), .wr_mss(wr_mss), .wr_mss_val(wr_mss_val),
        .wr_scc_set(wr_scc_set), .arb_lost(arb_lost), .last_bit(last_bit),
        .xmit(xmit), .addr_slave(addr_slave), .gen_call(gen_call)
    );

    // Flags as {arb_lost, last_bit, xmit, addr_slave, gen_call}.
    typedef struct packed {
        logic [2:0] ev;   // {start, rstart, stop}
        logic       bd;
        logic [7:0] rb;
        logic       scl, sda, so, cg;
        logic [3:0] bi;
        logic       ms, itf;
        logic [3:0] wr;   // {int_clr, mss_wr, mss_val, scc}
        logic [4:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{3'b000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000}, // idle
        '{3'b100,1'b0,8'h00,1'b1,1'b1,1'b1,1'b1,4'd0,1'b1,1'b0,4'b0000,5'b00100}, // R7 master start
        '{3'b000,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,4'd0,1'b1,1'b0,4'b0000,5'b00100},
        '{3'b000,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,4'd1,1'b1,1'b0,4'b0000,5'b10000}, // R2 mismatch
        '{3'b000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd1,1'b1,1'b0,4'b0110,5'b00000}, // R5 mss write 1
        '{3'b001,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000},
        '{3'b100,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000}, // slave start
        '{3'b000,1'b1,8'hA5,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00110}, // R7 R10 read match
        '{3'b000,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,4'd8,1'b0,1'b0,4'b0000,5'b00110},
        '{3'b000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd8,1'b0,1'b0,4'b0000,5'b01010}, // R6 R9 nack
        '{3'b010,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000}, // R13 rstart
        '{3'b000,1'b1,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00001}, // R12 gcall
        '{3'b000,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,4'd8,1'b0,1'b0,4'b0000,5'b00001},
        '{3'b000,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,4'd8,1'b0,1'b0,4'b0000,5'b00001}, // R6 ack 0
        '{3'b001,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000}, // R13 stop
        '{3'b100,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b1,1'b0,4'b0000,5'b00100},
        '{3'b000,1'b1,8'h31,1'b1,1'b1,1'b1,1'b0,4'd0,1'b1,1'b0,4'b0000,5'b00100}, // R12 no gc as master
        '{3'b000,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,4'd8,1'b1,1'b0,4'b0000,5'b00100},
        '{3'b000,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,4'd8,1'b1,1'b0,4'b0000,5'b00000}, // R9 master read
        '{3'b010,1'b0,8'h00,1'b1,1'b1,1'b1,1'b1,4'd0,1'b1,1'b0,4'b0000,5'b00100}, // R7 own rstart
        '{3'b000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b1,1'b1,4'b0001,5'b00000}, // R8 scc
        '{3'b001,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd0,1'b0,1'b0,4'b0000,5'b00000}
    };

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {arb_lost, last_bit, xmit, addr_slave, gen_call};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flags %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then release all strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        ev_start = 0; ev_rstart = 0; ev_stop = 0; byte_done = 0;
        wr_int_clr = 0; wr_mss = 0; wr_mss_val = 0; wr_scc_set = 0;
    endtask

    task automatic rx(input logic [7:0] b);
        byte_done = 1; rx_byte = b; tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        check("R1 reset", 5'b00000);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            {ev_start, ev_rstart, ev_stop} = VEC[i].ev;
            byte_done = VEC[i].bd; rx_byte = VEC[i].rb;
            scl_in = VEC[i].scl; sda_in = VEC[i].sda; sda_out = VEC[i].so;
            cond_gen = VEC[i].cg; bit_idx = VEC[i].bi;
            mss = VEC[i].ms; int_flag = VEC[i].itf;
            {wr_int_clr, wr_mss, wr_mss_val, wr_scc_set} = VEC[i].wr;
            tick();
            check($sformatf("vector %0d", i), VEC[i].exp);
        end
        scl_in = 1; sda_in = 1; cond_gen = 0; bit_idx = 0; mss = 0; int_flag = 0;
        tick();

        // R3: foreign repeated start after a complete byte
        mss = 1; cond_gen = 1; ev_start = 1; tick();
        cond_gen = 0; rx(8'h40);
        scl_in = 0; bit_idx = 8; tick();
        scl_in = 1; sda_in = 0; tick();
        check("R6 master ack", 5'b00100);
        sda_in = 1; bit_idx = 0; ev_rstart = 1; tick();
        check("R3 foreign rstart", 5'b10000);
        wr_int_clr = 1; tick();
        check("R5 int clear", 5'b00000);
        ev_stop = 1; tick();

        // R4: SCL pulled low while generating a condition
        cond_gen = 1; ev_start = 1; tick();
        scl_in = 0; tick();
        check("R4 scl fall", 5'b10000);
        scl_in = 1; cond_gen = 0; ev_stop = 1; wr_int_clr = 1; tick();
        check("R5 clear with stop", 5'b00000);

        // R5: write clear beats same-cycle mismatch
        ev_start = 1; tick();
        scl_in = 0; bit_idx = 1; tick();
        scl_in = 1; sda_in = 0; wr_int_clr = 1; tick();
        check("R5 write priority", 5'b00000);
        sda_in = 1; ev_stop = 1; tick();

        // R8: master-select write needs a pending interrupt
        ev_start = 1; bit_idx = 0; tick();
        int_flag = 0; wr_mss = 1; wr_mss_val = 0; tick();
        check("R8 no interrupt", 5'b00100);
        int_flag = 1; wr_mss = 1; wr_mss_val = 0; tick();
        check("R8 mss clear in interrupt", 5'b00000);
        int_flag = 0; mss = 0; ev_stop = 1; tick();

        // R11: 10-bit addressing
        ten_bit_en = 1; own_addr = 10'h2A7;
        ev_start = 1; tick();
        rx(8'hF4);
        check("R11 prefix only", 5'b00000);
        rx(8'hA7);
        check("R11 full match", 5'b00010);
        ev_start = 1; tick();
        check("R13 start clears", 5'b00000);
        rx(8'hF4); rx(8'hA6);
        check("R11 low byte wrong", 5'b00000);
        ev_rstart = 1; tick();
        rx(8'hF2); rx(8'hA7);
        check("R11 prefix wrong", 5'b00000);
        ev_stop = 1; tick();

        // R10: 7-bit mismatch and 7-bit write match
        ten_bit_en = 0; own_addr = 10'h052;
        ev_start = 1; tick();
        rx(8'hA6);
        check("R10 mismatch", 5'b00000);
        ev_rstart = 1; tick();
        rx(8'hA4);
        check("R10 R9 write match", 5'b00010);
        ev_stop = 1; tick();

        // R1: reset with flags set
        ev_start = 1; tick();
        rx(8'h00);
        check("R12 gcall", 5'b00001);
        rst_n = 0; tick();
        check("R1 reset clears", 5'b00000);
        rst_n = 1; tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule